// File: doc/BRIEF.md
# Display Panel Power Sequencer

This block drives the three enables of a display panel: the panel supply, the video data output and the backlight. When the power request goes high it turns these on one at a time: supply first, then data, then backlight. When the request goes low it turns them off in the opposite order. Between each pair of steps it waits a programmable number of ticks of an external 1 ms strobe. There are four delays: two for power-up and two for power-down. Each delay is 16 bits wide.

If the request drops before power-up has finished, the sequencer unwinds from the point it has reached. It removes the enables in reverse order and still waits the off-delays. While power-down is running, the request is ignored until every enable is off. A status pair reports the sequencer state: `ready` means fully on, and `busy` means some step is still under way.

Top module: `pnl_pwr_seq`

## Requirements
- R1: While reset is active, and after it is released with the request low, `supply_en`, `data_en`, `bklt_en`, `ready` and `busy` are all 0.
- R2: When the request is high, power-up runs as follows. `supply_en` rises first. `data_en` rises after `on_dly_a` further tick pulses. `bklt_en` rises after `on_dly_b` further tick pulses. While a delay is running, the wait advances only on tick pulses.
- R3: When the request is seen low with all enables on, `bklt_en` falls on that same clock edge. `data_en` falls after `off_dly_a` further ticks. `supply_en` falls after `off_dly_b` further ticks.
- R4: A delay value of 0 moves to the next step on the next clock edge, without waiting for any tick.
- R5: The request may drop while only the supply is on. In that case `data_en` never rises, and `supply_en` falls `off_dly_b` ticks after the edge at which the drop is seen.
- R6: The request may drop while supply and data are on but the backlight is not. In that case `bklt_en` never rises, and `data_en` falls `off_dly_a` ticks after the drop. `supply_en` then falls after `off_dly_b` more ticks.
- R7: If the request goes high again during power-down, power-down still runs to all-off. Power-up then starts again from the supply step.
- R8: `ready` is 1 exactly when all three enables are on. `busy` is 1 exactly when the enables are neither all off nor all on.
- R9: `data_en` is never 1 without `supply_en`, and `bklt_en` is never 1 without `data_en`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pwr_req | input | 1 | 1 requests panel on, 0 requests off |
| ms_tick | input | 1 | One-cycle strobe every millisecond |
| on_dly_a | input | DLY_W | Ticks from supply on to data on |
| on_dly_b | input | DLY_W | Ticks from data on to backlight on |
| off_dly_a | input | DLY_W | Ticks from backlight off to data off |
| off_dly_b | input | DLY_W | Ticks from data off to supply off |
| supply_en | output | 1 | Panel supply enable |
| data_en | output | 1 | Video data output enable |
| bklt_en | output | 1 | Backlight enable |
| ready | output | 1 | All enables on |
| busy | output | 1 | A sequencing step is in progress |

## Verification
The bench builds the block with the default 16-bit delay width. It drives a tick strobe every fourth clock and uses small delay values, including zero. This keeps full sequences, zero-delay shortcuts and early aborts within a short run. The bench counts the tick strobes between successive enable changes, so every programmed delay is checked exactly. It also drops the request at known tick positions, so the unwind paths from both power-up waits can be checked against their off-delays. The full 16-bit delay range is carried by the counter but is not exercised at its upper end.

// File: rtl/pnl_seq_pkg.sv
package pnl_seq_pkg;

  typedef enum logic [2:0] {
    ST_OFF      = 3'd0,
    ST_SUP_WAIT = 3'd1,
    ST_DAT_WAIT = 3'd2,
    ST_ON       = 3'd3,
    ST_BL_WAIT  = 3'd4,
    ST_DOF_WAIT = 3'd5
  } seq_st_t;

  // enable vector is {backlight, data, supply}
  function automatic logic [2:0] en_of(seq_st_t st);
    case (st)
      ST_SUP_WAIT: en_of = 3'b001;
      ST_DAT_WAIT: en_of = 3'b011;
      ST_ON:       en_of = 3'b111;
      ST_BL_WAIT:  en_of = 3'b011;
      ST_DOF_WAIT: en_of = 3'b001;
      default:     en_of = 3'b000;
    endcase
  endfunction

  function automatic logic is_wait(seq_st_t st);
    is_wait = (st == ST_SUP_WAIT) || (st == ST_DAT_WAIT) ||
              (st == ST_BL_WAIT)  || (st == ST_DOF_WAIT);
  endfunction

endpackage

// File: rtl/pnl_seq_timer.sv
module pnl_seq_timer #(
  parameter int DLY_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [DLY_W-1:0] load_val,
  input  logic             tick,
  output logic             expired
);

  logic [DLY_W-1:0] cnt_q;
  logic [DLY_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load || (tick && (cnt_q != '0));
    cnt_d  = load ? load_val : (cnt_q - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);

  // R2: a running wait moves only on a tick
  p_hold_no_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !tick) |=> $stable(cnt_q));

  // R4: a load takes the programmed value, zero included
  p_load_value_r4: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q == $past(load_val)));

endmodule

// File: rtl/pnl_seq_fsm.sv
module pnl_seq_fsm
  import pnl_seq_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    req,
  input  logic    expired,
  output seq_st_t st_q,
  output seq_st_t st_d,
  output logic    load
);

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_OFF:      if (req) st_d = ST_SUP_WAIT;
      ST_SUP_WAIT: if (!req) st_d = ST_DOF_WAIT;
                   else if (expired) st_d = ST_DAT_WAIT;
      ST_DAT_WAIT: if (!req) st_d = ST_BL_WAIT;
                   else if (expired) st_d = ST_ON;
      ST_ON:       if (!req) st_d = ST_BL_WAIT;
      ST_BL_WAIT:  if (expired) st_d = ST_DOF_WAIT;
      ST_DOF_WAIT: if (expired) st_d = ST_OFF;
      default:     st_d = ST_OFF;
    endcase
    load = (st_d != st_q) && is_wait(st_d);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_OFF;
    else        st_q <= st_d;
  end

  // R7: once power-down started, it never turns back toward power-up
  p_no_reversal_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_BL_WAIT) |=> (st_q == ST_BL_WAIT || st_q == ST_DOF_WAIT));

  // R3: a low request in the on state leaves it on the next edge
  p_leave_on_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_ON && !req) |=> (st_q == ST_BL_WAIT));

endmodule

// File: rtl/pnl_seq_out.sv
module pnl_seq_out
  import pnl_seq_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  seq_st_t st_q,
  input  seq_st_t st_d,
  output logic    supply_en,
  output logic    data_en,
  output logic    bklt_en,
  output logic    ready,
  output logic    busy
);

  logic [2:0] en_d;
  logic       upd;

  always_comb begin
    en_d = en_of(st_d);
    upd  = (st_d != st_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {bklt_en, data_en, supply_en} <= 3'b000;
      ready <= 1'b0;
      busy  <= 1'b0;
    end else if (upd) begin
      {bklt_en, data_en, supply_en} <= en_d;
      ready <= (st_d == ST_ON);
      busy  <= is_wait(st_d);
    end
  end

  // R9: dependency between enables
  p_data_needs_supply_r9: assert property (@(posedge clk) disable iff (!rst_n)
    data_en |-> supply_en);
  p_bklt_needs_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bklt_en |-> data_en);

  // R8: status agrees with enables
  p_ready_all_on_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (supply_en && data_en && bklt_en));
  p_busy_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && ready));

  // R2: backlight rises only after data was already on
  p_bklt_after_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bklt_en) |-> $past(data_en));

  // R3: supply falls only after data was already off
  p_supply_after_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(supply_en) |-> !$past(data_en));

endmodule

// File: rtl/pnl_pwr_seq.sv
module pnl_pwr_seq
  import pnl_seq_pkg::*;
#(
  parameter int DLY_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwr_req,
  input  logic             ms_tick,
  input  logic [DLY_W-1:0] on_dly_a,
  input  logic [DLY_W-1:0] on_dly_b,
  input  logic [DLY_W-1:0] off_dly_a,
  input  logic [DLY_W-1:0] off_dly_b,
  output logic             supply_en,
  output logic             data_en,
  output logic             bklt_en,
  output logic             ready,
  output logic             busy
);

  logic [1:0]       rst_sync_q;
  logic             rst_s_n;
  seq_st_t          st_q;
  seq_st_t          st_d;
  logic             load;
  logic             expired;
  logic [DLY_W-1:0] dly_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s_n = rst_sync_q[1];

  always_comb begin
    case (st_d)
      ST_SUP_WAIT: dly_sel = on_dly_a;
      ST_DAT_WAIT: dly_sel = on_dly_b;
      ST_BL_WAIT:  dly_sel = off_dly_a;
      ST_DOF_WAIT: dly_sel = off_dly_b;
      default:     dly_sel = '0;
    endcase
  end

  pnl_seq_fsm u_fsm (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .req     (pwr_req),
    .expired (expired),
    .st_q    (st_q),
    .st_d    (st_d),
    .load    (load)
  );

  pnl_seq_timer #(.DLY_W(DLY_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .load     (load),
    .load_val (dly_sel),
    .tick     (ms_tick),
    .expired  (expired)
  );

  pnl_seq_out u_out (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .st_q      (st_q),
    .st_d      (st_d),
    .supply_en (supply_en),
    .data_en   (data_en),
    .bklt_en   (bklt_en),
    .ready     (ready),
    .busy      (busy)
  );

endmodule

// File: tb/pnl_pwr_seq_test.sv
`timescale 1ns/1ps
module pnl_pwr_seq_test;

  localparam int DLY_W = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             pwr_req = 1'b0;
  logic             ms_tick = 1'b0;
  logic [DLY_W-1:0] on_dly_a = '0;
  logic [DLY_W-1:0] on_dly_b = '0;
  logic [DLY_W-1:0] off_dly_a = '0;
  logic [DLY_W-1:0] off_dly_b = '0;
  logic supply_en, data_en, bklt_en, ready, busy;

  always #4 clk = ~clk;

  pnl_pwr_seq #(.DLY_W(DLY_W)) uut (
    .clk(clk), .rst_n(rst_n), .pwr_req(pwr_req), .ms_tick(ms_tick),
    .on_dly_a(on_dly_a), .on_dly_b(on_dly_b),
    .off_dly_a(off_dly_a), .off_dly_b(off_dly_b),
    .supply_en(supply_en), .data_en(data_en), .bklt_en(bklt_en),
    .ready(ready), .busy(busy)
  );

  typedef struct {
    logic [2:0] en;
    int         ticks;
    string      tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_checks = 0;
  int   n_fail = 0;
  int   ticks_since = 0;
  logic [2:0] mon_en = 3'b000;
  bit   done = 0;

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic push(input logic [2:0] en, input int ticks, input string tag);
    exp_t e;
    e.en = en; e.ticks = ticks; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  // tick generator: one-cycle strobe every fourth clock
  initial begin
    int ph = 0;
    forever begin
      @(negedge clk);
      ph = (ph + 1) % 4;
      ms_tick = (ph == 0);
    end
  end

  // monitor / scoreboard
  initial begin
    logic [2:0] cur;
    logic       t;
    forever begin
      @(posedge clk);
      t = ms_tick;
      #1;
      cur = {bklt_en, data_en, supply_en};
      if (cur != mon_en) begin
        if (exp_q.size() == 0) begin
          check(0, "unexpected enable change", int'(cur), int'(mon_en));
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(cur == e.en, {e.tag, " enables"}, int'(cur), int'(e.en));
          if (e.ticks >= 0)
            check(ticks_since == e.ticks, {e.tag, " ticks"}, ticks_since, e.ticks);
          check(ready == (cur == 3'b111), "R8 ready", int'(ready), int'(cur == 3'b111));
          check(busy == (cur != 3'b000 && cur != 3'b111), "R8 busy", int'(busy),
                int'(cur != 3'b000 && cur != 3'b111));
        end
        ticks_since = 0;
      end else begin
        ticks_since += int'(t);
      end
      mon_en = cur;
    end
  end

  task automatic wait_en(input logic [2:0] v);
    while (mon_en != v) @(negedge clk);
  endtask

  task automatic wait_drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (12) @(negedge clk);
  endtask

  task automatic set_dly(input int a, input int b, input int c, input int d);
    on_dly_a = DLY_W'(a); on_dly_b = DLY_W'(b);
    off_dly_a = DLY_W'(c); off_dly_b = DLY_W'(d);
  endtask

  // drop request right after a tick edge, return ticks counted so far
  task automatic drop_after_ticks(input int n, output int base);
    repeat (n) @(posedge clk iff ms_tick);
    @(negedge clk);
    base = ticks_since;
    pwr_req = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int base;
    repeat (3) @(negedge clk);
    check({supply_en, data_en, bklt_en, ready, busy} == 5'b0, "R1 in reset",
          int'({supply_en, data_en, bklt_en, ready, busy}), 0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    check({supply_en, data_en, bklt_en, ready, busy} == 5'b0, "R1 after reset",
          int'({supply_en, data_en, bklt_en, ready, busy}), 0);

    // R2 / R3: full on then full off
    set_dly(3, 5, 2, 4);
    push(3'b001, -1, "R2 supply on");
    push(3'b011, 3, "R2 data on");
    push(3'b111, 5, "R2 backlight on");
    pwr_req = 1'b1;
    wait_en(3'b111);
    repeat (20) @(negedge clk);
    check(ready == 1'b1 && busy == 1'b0, "R8 hold on", int'({ready, busy}), 2);
    push(3'b011, -1, "R3 backlight off");
    push(3'b001, 2, "R3 data off");
    push(3'b000, 4, "R3 supply off");
    pwr_req = 1'b0;
    wait_drain();

    // R4: zero delays
    set_dly(0, 0, 0, 0);
    push(3'b001, -1, "R4 supply on");
    push(3'b011, 0, "R4 data on");
    push(3'b111, 0, "R4 backlight on");
    pwr_req = 1'b1;
    wait_en(3'b111);
    repeat (3) @(negedge clk);
    push(3'b011, -1, "R4 backlight off");
    push(3'b001, 0, "R4 data off");
    push(3'b000, 0, "R4 supply off");
    pwr_req = 1'b0;
    wait_drain();

    // R5: abort while only supply is on
    set_dly(10, 3, 2, 3);
    push(3'b001, -1, "R5 supply on");
    pwr_req = 1'b1;
    wait_en(3'b001);
    drop_after_ticks(2, base);
    push(3'b000, base + 3, "R5 supply off");
    wait_drain();
    check(mon_en == 3'b000, "R5 final off", int'(mon_en), 0);

    // R6: abort while supply and data are on
    set_dly(1, 10, 3, 2);
    push(3'b001, -1, "R6 supply on");
    push(3'b011, 1, "R6 data on");
    pwr_req = 1'b1;
    wait_en(3'b011);
    drop_after_ticks(2, base);
    push(3'b001, base + 3, "R6 data off");
    push(3'b000, 2, "R6 supply off");
    wait_drain();

    // R7: request raised again during power-down
    set_dly(2, 2, 3, 3);
    push(3'b001, -1, "R7 supply on");
    push(3'b011, 2, "R7 data on");
    push(3'b111, 2, "R7 backlight on");
    pwr_req = 1'b1;
    wait_en(3'b111);
    repeat (4) @(negedge clk);
    push(3'b011, -1, "R7 backlight off");
    push(3'b001, 3, "R7 data off");
    push(3'b000, 3, "R7 supply off");
    push(3'b001, -1, "R7 restart supply");
    push(3'b011, 2, "R7 restart data");
    push(3'b111, 2, "R7 restart backlight");
    pwr_req = 1'b0;
    @(negedge clk);
    @(negedge clk);
    pwr_req = 1'b1;
    wait_drain();
    push(3'b011, -1, "R7 final backlight off");
    push(3'b001, 3, "R7 final data off");
    push(3'b000, 3, "R7 final supply off");
    pwr_req = 1'b0;
    wait_drain();
    check(ready == 1'b0 && busy == 1'b0, "R8 idle status", int'({ready, busy}), 0);
    check(exp_q.size() == 0, "R9 all items seen", exp_q.size(), 0);

    finish_run();
  end

endmodule